// File: doc/BRIEF.md
# Software Write-Lock Guard for a Byte-Addressed Memory

This block sits beside a 256-byte memory that a serial bus slave fills one byte at a time. It does not move data and it does not decode the bus. It watches the stream of committed byte writes: an address, a data byte, a valid strobe, and markers for the start and the stop of each bus transaction. For every address it is asked about, it says whether a write may go ahead. The memory's write enable is gated with that answer.

The address space has three partitions. A 3-bit partition-select register, loaded by writing to a configuration address, chooses which partitions a lock covers. A two-byte password, written to two fixed addresses in ascending order within one transaction, engages the lock. A second password releases it. The configuration address can only be changed while the partition that holds it is not locked. Because password tracking is cleared at every transaction boundary, that partition cannot be unlocked with a password split across two transactions.

A hardware write-protect input overrides everything. While it is high, no address is writable and no write changes the lock state. The block gives two answers: one for the address of the write in flight, and one for a free query address that the surrounding logic may use.

Top module: `mem_lock_guard`

## Requirements
- R1: After reset the lock is released and the partition select is 000b, so with write-protect low every address reports permitted.
- R2: Partition index 0 covers addresses 00h–7Fh, index 1 covers 80h–F7h, and index 2 covers F8h–FFh. Select bit n applies to partition n.
- R3: A permitted write to FAh loads data bits 2:0 into the partition select, and data bits 7:3 are ignored. No other write changes the select.
- R4: Writing 56h to FBh and then 25h to FCh in one transaction engages the lock. An address is then refused exactly when the select bit of its partition is 1.
- R5: Writing 67h to FBh and then 36h to FCh in one transaction releases the lock.
- R6: A password pair only counts when FBh is written before FCh with no START or STOP marker between them. A wrong first byte, a wrong second byte, a reversed order or a split pair leaves the lock state unchanged.
- R7: While the lock is engaged and select bit 2 is 1, a write to FAh is refused and leaves the select unchanged.
- R8: While write-protect is high, both permit outputs are 0 for every address, and no write changes the select, the lock state or the password tracking.
- R9: Password writes to FBh and FCh are recognised even while the partition holding them is locked, so the release pair works from the locked state.
- R10: The write-permit output reflects the state before the write in the same cycle. A state change takes effect on both outputs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | One-cycle marker for a bus START or repeated START |
| txnStop | input | 1 | One-cycle marker for a bus STOP |
| wrValid | input | 1 | A committed byte write is presented this cycle |
| wrAddr | input | 8 | Address of the byte write |
| wrData | input | 8 | Data of the byte write |
| wpIn | input | 1 | Hardware write-protect, active high |
| queryAddr | input | 8 | Free address to evaluate |
| wrPermit | output | 1 | The write at wrAddr may be stored |
| queryPermit | output | 1 | A write at queryAddr would be stored |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, the partition bounds at 80h and F8h, and the four password bytes. Under these parameters a random query address reaches every one of the 256 locations, and the random write stream biases addresses towards FAh, FBh and FCh and data towards the four password bytes. This lets engage, release, split pairs and refused configuration writes happen many times, and each is compared with a reference model written from the requirements. Directed steps pin down the partition boundaries 7Fh/80h and F7h/F8h, the split-pair release attempt, and the write-protect override.

// File: rtl/mlg_pkg.sv
package mlg_pkg;
  typedef enum logic [1:0] {
    PEND_NONE   = 2'd0,
    PEND_LOCK   = 2'd1,
    PEND_UNLOCK = 2'd2
  } pend_e;

  typedef struct packed {
    logic engage;
    logic disengage;
    logic cfgLoad;
  } lock_stb_t;
endpackage

// File: rtl/mlg_ctrl.sv
module mlg_ctrl
  import mlg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hFA,
  parameter logic [ADDR_W-1:0] PW_HI_ADDR = 8'hFB,
  parameter logic [ADDR_W-1:0] PW_LO_ADDR = 8'hFC,
  parameter logic [DATA_W-1:0] LOCK_HI = 8'h56,
  parameter logic [DATA_W-1:0] LOCK_LO = 8'h25,
  parameter logic [DATA_W-1:0] OPEN_HI = 8'h67,
  parameter logic [DATA_W-1:0] OPEN_LO = 8'h36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              txnStop,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpIn,
  input  logic              wrPermit,
  output lock_stb_t         stb
);
  pend_e pendQ;
  logic  boundary, liveWrite, hitHi, hitLo, hitCfg;

  assign boundary  = txnStart | txnStop;
  assign liveWrite = wrValid & ~wpIn & ~boundary;
  assign hitHi     = (wrAddr == PW_HI_ADDR);
  assign hitLo     = (wrAddr == PW_LO_ADDR);
  assign hitCfg    = (wrAddr == CFG_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN || boundary) begin
      pendQ <= PEND_NONE;
    end else if (liveWrite && hitHi) begin
      if (wrData == LOCK_HI)      pendQ <= PEND_LOCK;
      else if (wrData == OPEN_HI) pendQ <= PEND_UNLOCK;
      else                        pendQ <= PEND_NONE;
    end else if (liveWrite && hitLo) begin
      pendQ <= PEND_NONE;
    end
  end

  always_comb begin
    stb           = '0;
    stb.engage    = liveWrite & hitLo & (pendQ == PEND_LOCK)   & (wrData == LOCK_LO);
    stb.disengage = liveWrite & hitLo & (pendQ == PEND_UNLOCK) & (wrData == OPEN_LO);
    stb.cfgLoad   = wrValid & hitCfg & wrPermit;
  end

  // R6: a transaction boundary always forgets a half-written password
  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (pendQ == PEND_NONE));
  // R4, R5: engage and release never fire together
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.engage, stb.disengage}));
  // R6: a pair completes only after a matching first byte was recorded
  assert_pair_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.engage || stb.disengage) |-> (pendQ != PEND_NONE));
endmodule

// File: rtl/mlg_datapath.sv
module mlg_datapath
  import mlg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] BLOCK_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lock_stb_t         stb,
  input  logic [SEL_W-1:0]  cfgData,
  input  logic              wpIn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] queryAddr,
  output logic              wrPermit,
  output logic              queryPermit
);
  localparam int LOOKUPS = 2;
  localparam int PART_W = $clog2(SEL_W);

  logic [SEL_W-1:0]  cfgReg;
  logic              lockedReg;
  logic [ADDR_W-1:0] lkAddr   [LOOKUPS];
  logic              lkPermit [LOOKUPS];

  function automatic logic [PART_W-1:0] partOf(input logic [ADDR_W-1:0] a);
    if (a >= PAGE_BASE)       return PART_W'(2);
    else if (a >= BLOCK_BASE) return PART_W'(1);
    else                      return PART_W'(0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= '0;
      lockedReg <= 1'b0;
    end else begin
      if (stb.cfgLoad)   cfgReg    <= cfgData;
      if (stb.engage)    lockedReg <= 1'b1;
      if (stb.disengage) lockedReg <= 1'b0;
    end
  end

  assign lkAddr[0] = wrAddr;
  assign lkAddr[1] = queryAddr;

  for (genvar g = 0; g < LOOKUPS; g++) begin : g_lookup
    assign lkPermit[g] = ~wpIn & ~(lockedReg & cfgReg[partOf(lkAddr[g])]);
  end

  assign wrPermit    = lkPermit[0];
  assign queryPermit = lkPermit[1];

  // R3: the select changes only on a load strobe
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgLoad |=> $stable(cfgReg));
  // R7: no load strobe arrives while the page holding the select is locked
  assert_cfg_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgLoad |-> !(lockedReg && cfgReg[SEL_W-1]));
  // R4: the lock engages only after an engage strobe
  assert_lock_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedReg) |-> $past(stb.engage));
  // R5: the lock releases only after a release strobe
  assert_unlock_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockedReg) |-> $past(stb.disengage));
  // R8: write-protect freezes all lock state
  assert_wp_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    wpIn |=> ($stable(cfgReg) && $stable(lockedReg)));
endmodule

// File: rtl/mem_lock_guard.sv
module mem_lock_guard
  import mlg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] BLOCK_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 8'hF8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hFA,
  parameter logic [ADDR_W-1:0] PW_HI_ADDR = 8'hFB,
  parameter logic [ADDR_W-1:0] PW_LO_ADDR = 8'hFC,
  parameter logic [DATA_W-1:0] LOCK_HI = 8'h56,
  parameter logic [DATA_W-1:0] LOCK_LO = 8'h25,
  parameter logic [DATA_W-1:0] OPEN_HI = 8'h67,
  parameter logic [DATA_W-1:0] OPEN_LO = 8'h36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              txnStop,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpIn,
  input  logic [ADDR_W-1:0] queryAddr,
  output logic              wrPermit,
  output logic              queryPermit
);
  lock_stb_t stb;

  mlg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .PW_HI_ADDR(PW_HI_ADDR), .PW_LO_ADDR(PW_LO_ADDR),
    .LOCK_HI(LOCK_HI), .LOCK_LO(LOCK_LO), .OPEN_HI(OPEN_HI), .OPEN_LO(OPEN_LO)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnStop(txnStop),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wpIn(wpIn),
    .wrPermit(wrPermit), .stb(stb)
  );

  mlg_datapath #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BLOCK_BASE(BLOCK_BASE), .PAGE_BASE(PAGE_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgData(wrData[SEL_W-1:0]), .wpIn(wpIn),
    .wrAddr(wrAddr), .queryAddr(queryAddr),
    .wrPermit(wrPermit), .queryPermit(queryPermit)
  );
endmodule

// File: tb/mem_lock_guard_tb.sv
module mem_lock_guard_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnStart = 1'b0, txnStop = 1'b0, wrValid = 1'b0, wpIn = 1'b0;
  logic [7:0] wrAddr = '0, wrData = '0, queryAddr = '0;
  logic wrPermit, queryPermit;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  logic [2:0] mCfg = 3'b000;
  logic       mLocked = 1'b0;
  int         mPend = 0; // 0 none, 1 lock first byte seen, 2 release first byte seen

  always #2 clk = ~clk;

  mem_lock_guard u_dut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnStop(txnStop),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wpIn(wpIn),
    .queryAddr(queryAddr), .wrPermit(wrPermit), .queryPermit(queryPermit)
  );

  function automatic int partIdx(input logic [7:0] a);
    if (a >= 8'hF8) return 2;
    if (a >= 8'h80) return 1;
    return 0;
  endfunction

  function automatic logic expPermit(input logic [7:0] a);
    return !wpIn && !(mLocked && mCfg[partIdx(a)]);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic query(input string req, input logic [7:0] a);
    @(negedge clk);
    queryAddr = a;
    #1 check(req, queryPermit, expPermit(a));
  endtask

  task automatic marker(input bit isStop);
    @(negedge clk);
    if (isStop) txnStop = 1'b1; else txnStart = 1'b1;
    @(posedge clk);
    #1 txnStop = 1'b0; txnStart = 1'b0;
    mPend = 0;
  endtask

  task automatic doWrite(input string req, input logic [7:0] a, input logic [7:0] d);
    logic ok;
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    ok = expPermit(a);
    #1 check(req, wrPermit, ok);
    @(posedge clk);
    #1 wrValid = 1'b0;
    if (!wpIn) begin
      if (a == 8'hFA && ok) mCfg = d[2:0];
      if (a == 8'hFB) mPend = (d == 8'h56) ? 1 : (d == 8'h67) ? 2 : 0;
      else if (a == 8'hFC) begin
        if (mPend == 1 && d == 8'h25) mLocked = 1'b1;
        if (mPend == 2 && d == 8'h36) mLocked = 1'b0;
        mPend = 0;
      end
    end
  endtask

  task automatic pair(input string req, input logic [7:0] hi, input logic [7:0] lo);
    marker(0);
    doWrite(req, 8'hFB, hi);
    doWrite(req, 8'hFC, lo);
    marker(1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state, R2 boundaries
    query("R1", 8'h00); query("R1", 8'h90); query("R1", 8'hFF);
    marker(0);
    doWrite("R3", 8'hFA, 8'hFB);           // upper bits dropped -> 011
    marker(1);
    pair("R4", 8'h56, 8'h25);
    query("R4", 8'h10); query("R2", 8'h7F); query("R2", 8'h80);
    query("R2", 8'hF7); query("R2", 8'hF8); query("R4", 8'hF9);
    pair("R5", 8'h67, 8'h36);
    query("R5", 8'h10); query("R5", 8'h90);
    // lock the upper page only
    marker(0); doWrite("R3", 8'hFA, 8'h04); marker(1);
    pair("R4", 8'h56, 8'h25);
    query("R4", 8'hFA); query("R2", 8'hF8); query("R4", 8'h7F);
    marker(0); doWrite("R7", 8'hFA, 8'h07); marker(1);
    query("R7", 8'h20); query("R7", 8'hA0);
    // split release attempt
    marker(0); doWrite("R6", 8'hFB, 8'h67); marker(1);
    marker(0); doWrite("R6", 8'hFC, 8'h36); marker(1);
    query("R6", 8'hFC);
    pair("R6", 8'h67, 8'h25);              // wrong second byte
    query("R6", 8'hFB);
    // release from locked page
    pair("R9", 8'h67, 8'h36);
    query("R9", 8'hFA);
    // WP override
    pair("R4", 8'h56, 8'h25);
    @(negedge clk); wpIn = 1'b1;
    query("R8", 8'h00); query("R8", 8'h90); query("R8", 8'hF9);
    pair("R8", 8'h67, 8'h36);
    @(negedge clk); wpIn = 1'b0;
    query("R8", 8'hF9); query("R8", 8'h10);
    // R10 write permit same cycle as FA load
    pair("R10", 8'h67, 8'h36);
    marker(0); doWrite("R10", 8'hFA, 8'h01); marker(1);
    pair("R10", 8'h56, 8'h25);
    doWrite("R10", 8'h05, 8'hAA);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] a, d;
      r = $urandom % 16;
      if ($urandom % 25 == 0) begin @(negedge clk); wpIn = ~wpIn; end
      if (r < 2) marker(0);
      else if (r < 4) marker(1);
      else begin
        case ($urandom % 4)
          0: a = 8'hFA;
          1: a = 8'hFB;
          2: a = 8'hFC;
          default: a = 8'($urandom);
        endcase
        case ($urandom % 5)
          0: d = 8'h56;
          1: d = 8'h25;
          2: d = 8'h67;
          3: d = 8'h36;
          default: d = 8'($urandom);
        endcase
        doWrite("R4/R5/R6 random", a, d);
      end
      query("R2/R8 random", 8'($urandom));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule